// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block sits between an external priority encoder and a processor's exception sequencer. It watches a three-bit code that names the most urgent pending hardware request, with 1 the least urgent, 7 the most urgent and 0 meaning nothing is pending. It compares that code against the interrupt mask held in the processor status. When it decides to take a request, it raises the mask to the serviced level and forces the processor into supervisor state. Supervisor state also selects the supervisor stack pointer. The block then waits for the bus acknowledge cycle to report how the vector is to be found.

The acknowledge reports one of three outcomes. A device can supply its own 8-bit vector number. The vector can be derived automatically from the level. Or no device answered, which gives a spurious acknowledge. The block turns the outcome into a vector number and a byte address in a table of 256 four-byte entries. Level 7 is non-maskable: the block takes it once each time the code changes to 7. The status register port lets supervisor software lower or raise the mask and leave supervisor state. Writes made in user state are refused.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, supervisor state is set, the stack select output points at the supervisor stack, the mask equals parameter RST_MASK (default 7), and take_o, ack_pend_o and vec_valid_o are low.
- R2: A level code is acted on only after it has been seen on two consecutive clock edges. A level applied before edge E1 and held produces take_o high in the cycle after edge E3. A code present for a single edge is never taken.
- R3: A level from 1 to 6 is taken only when it is strictly greater than the current mask. Level 0 is never taken.
- R4: Level 7 is taken whatever the mask holds, once for each change of the filtered code to 7. Holding 7 does not cause a second take.
- R5: On a take, take_o is high for exactly one cycle. In that same cycle the mask equals the taken level, supervisor state and the supervisor stack select are set, and ack_pend_o is high with ack_lvl_o equal to the level. No further request is taken until the acknowledge arrives.
- R6: While ack_pend_o is high, an ack_valid_i pulse ends the wait, and in the next cycle vec_valid_o pulses. Kind 2'b00 gives the device vector ack_vec_i. Kind 2'b01 gives 24 plus the level. Kinds 2'b10 and 2'b11 give 24. vec_addr_o is four times the vector number. An ack_valid_i pulse when nothing is pending is ignored.
- R7: A status write in supervisor state loads the supervisor bit and the mask at the next edge. A status write in user state leaves both unchanged.
- R8: When a take and a status write fall on the same edge, the take wins and the write is discarded.
- R9: Once a request has been acknowledged, a pending request of a higher level is taken on the cycle after the acknowledge. Requests at or below the raised mask stay untaken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lvl_i | input | 3 | Encoded highest pending level, 0 means none |
| sr_wr_en_i | input | 1 | Status write request |
| sr_wr_sup_i | input | 1 | Supervisor bit to write |
| sr_wr_mask_i | input | 3 | Mask value to write |
| ack_valid_i | input | 1 | Acknowledge outcome is valid |
| ack_kind_i | input | 2 | 00 device vector, 01 autovector, 1x spurious |
| ack_vec_i | input | 8 | Device-supplied vector number |
| take_o | output | 1 | One-cycle pulse when a request is taken |
| ack_pend_o | output | 1 | Waiting for the acknowledge outcome |
| ack_lvl_o | output | 3 | Level being serviced |
| vec_valid_o | output | 1 | Vector outputs are valid for one cycle |
| vec_num_o | output | 8 | Vector number |
| vec_addr_o | output | 10 | Vector byte address |
| mask_o | output | 3 | Current interrupt mask |
| sup_o | output | 1 | Current supervisor state |
| ssp_sel_o | output | 1 | High selects the supervisor stack pointer |

## Verification
The two functions that can share one cycle are the take of a request and a status write. Both update the same supervisor bit and mask. The bench applies a level and then raises the status write strobe so that it is present on exactly the third edge after the level appeared, which is the edge that takes the request. That edge is expected to show take_o high with the mask equal to the taken level and supervisor state set, and no trace of the written values. A second overlap is also checked: a higher level that arrives while an acknowledge is pending must be taken on the cycle that follows the acknowledge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int LVL_W   = 3;
    localparam int VEC_W   = 8;
    localparam int VADDR_W = VEC_W + 2;

    localparam logic [LVL_W-1:0] LVL_NONE = '0;
    localparam logic [LVL_W-1:0] LVL_TOP  = '1;

    localparam logic [VEC_W-1:0] VEC_SPURIOUS = 8'd24;

    typedef enum logic [1:0] {
        ACK_DEVICE   = 2'b00,
        ACK_AUTO     = 2'b01,
        ACK_SPUR     = 2'b10,
        ACK_SPUR_ALT = 2'b11
    } ack_kind_e;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_WAIT = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic             sup;
        logic [LVL_W-1:0] mask;
    } status_t;

    typedef struct packed {
        logic               valid;
        logic [VEC_W-1:0]   num;
        logic [VADDR_W-1:0] addr;
    } vec_out_t;

    function automatic logic [VEC_W-1:0] auto_vec(input logic [LVL_W-1:0] lvl);
        return VEC_SPURIOUS + VEC_W'(lvl);
    endfunction

    function automatic logic [VADDR_W-1:0] vec_to_addr(input logic [VEC_W-1:0] num);
        return {num, 2'b00};
    endfunction

    function automatic logic lvl_wins(input logic [LVL_W-1:0] lvl,
                                      input logic [LVL_W-1:0] mask,
                                      input logic             top_pend);
        if (lvl == LVL_TOP)
            return top_pend;
        return (lvl != LVL_NONE) && (lvl > mask);
    endfunction

    function automatic logic [VEC_W-1:0] pick_vec(input logic [1:0]       kind,
                                                  input logic [VEC_W-1:0] dev,
                                                  input logic [LVL_W-1:0] lvl);
        logic [VEC_W-1:0] v;
        case (kind)
            ACK_DEVICE: v = dev;
            ACK_AUTO:   v = auto_vec(lvl);
            default:    v = VEC_SPURIOUS;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/irqc_lvl_filter.sv
module irqc_lvl_filter
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             top_clr_i,
    output logic [LVL_W-1:0] stable_o,
    output logic             top_pend_o
);

    logic [LVL_W-1:0] sample_q;
    logic [LVL_W-1:0] stable_q;
    logic [LVL_W-1:0] stable_d;
    logic             pend_q;
    logic             pend_d;

    always_comb begin
        stable_d = (lvl_i == sample_q) ? lvl_i : stable_q;
        if (stable_d != LVL_TOP)
            pend_d = 1'b0;
        else if (stable_q != LVL_TOP)
            pend_d = 1'b1;
        else if (top_clr_i)
            pend_d = 1'b0;
        else
            pend_d = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= LVL_NONE;
            stable_q <= LVL_NONE;
            pend_q   <= 1'b0;
        end else begin
            sample_q <= lvl_i;
            stable_q <= stable_d;
            pend_q   <= pend_d;
        end
    end

    assign stable_o   = stable_q;
    assign top_pend_o = pend_q;

    // R2: the filtered code moves only when the input matched the earlier sample
    p_filter_r2: assert property (@(posedge clk) disable iff (rst)
        (stable_q != $past(stable_q)) |-> ($past(lvl_i) == $past(sample_q)));

    // R4: a pending top-level request appears only on a change to the top level
    p_top_edge_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> ($past(stable_q) != LVL_TOP));

endmodule

// File: rtl/irqc_status.sv
module irqc_status
    import irqc_pkg::*;
#(
    parameter logic [LVL_W-1:0] RST_MASK = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  logic [LVL_W-1:0] accept_lvl_i,
    input  logic             wr_en_i,
    input  logic             wr_sup_i,
    input  logic [LVL_W-1:0] wr_mask_i,
    output status_t          status_o
);

    status_t st_q;
    status_t st_d;

    always_comb begin
        st_d = st_q;
        if (accept_i) begin
            st_d.sup  = 1'b1;
            st_d.mask = accept_lvl_i;
        end else if (wr_en_i && st_q.sup) begin
            st_d.sup  = wr_sup_i;
            st_d.mask = wr_mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sup  <= 1'b1;
            st_q.mask <= RST_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q;

    // R7: user-state writes leave the status untouched
    p_user_write_r7: assert property (@(posedge clk) disable iff (rst)
        (!st_q.sup && wr_en_i && !accept_i) |=> $stable(st_q));

    // R8: a take overrides any write on the same edge
    p_take_wins_r8: assert property (@(posedge clk) disable iff (rst)
        accept_i |=> (st_q.sup && st_q.mask == $past(accept_lvl_i)));

endmodule

// File: rtl/irqc_vector.sv
module irqc_vector
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ack_en_i,
    input  logic             ack_valid_i,
    input  logic [1:0]       ack_kind_i,
    input  logic [VEC_W-1:0] ack_vec_i,
    input  logic [LVL_W-1:0] lvl_i,
    output vec_out_t         vec_o
);

    vec_out_t         out_q;
    logic             fire;
    logic [VEC_W-1:0] num_d;

    assign fire  = ack_en_i && ack_valid_i;
    assign num_d = pick_vec(ack_kind_i, ack_vec_i, lvl_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= fire;
            if (fire) begin
                out_q.num  <= num_d;
                out_q.addr <= vec_to_addr(num_d);
            end
        end
    end

    assign vec_o = out_q;

    // R6: autovectors stay inside the reserved level range
    p_auto_range_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && ack_kind_i == ACK_AUTO) |=>
            (out_q.num >= 8'd25 && out_q.num <= 8'd31));

    // R6: a spurious outcome always yields the spurious vector
    p_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && ack_kind_i[1]) |=> (out_q.num == VEC_SPURIOUS));

    // R6: an acknowledge with nothing pending is ignored
    p_stray_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_valid_i && !ack_en_i) |=> !out_q.valid);

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irqc_pkg::*;
#(
    parameter logic [LVL_W-1:0] RST_MASK = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LVL_W-1:0]   irq_lvl_i,
    input  logic               sr_wr_en_i,
    input  logic               sr_wr_sup_i,
    input  logic [LVL_W-1:0]   sr_wr_mask_i,
    input  logic               ack_valid_i,
    input  logic [1:0]         ack_kind_i,
    input  logic [VEC_W-1:0]   ack_vec_i,
    output logic               take_o,
    output logic               ack_pend_o,
    output logic [LVL_W-1:0]   ack_lvl_o,
    output logic               vec_valid_o,
    output logic [VEC_W-1:0]   vec_num_o,
    output logic [VADDR_W-1:0] vec_addr_o,
    output logic [LVL_W-1:0]   mask_o,
    output logic               sup_o,
    output logic               ssp_sel_o
);

    ctl_state_e       state_q;
    logic             take_q;
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] stable_lvl;
    logic             top_pend;
    logic             accept;
    logic             ack_en;
    status_t          status;
    vec_out_t         vec;

    irqc_lvl_filter u_filter (
        .clk        (clk),
        .rst        (rst),
        .lvl_i      (irq_lvl_i),
        .top_clr_i  (accept),
        .stable_o   (stable_lvl),
        .top_pend_o (top_pend)
    );

    assign accept = (state_q == CTL_IDLE) && lvl_wins(stable_lvl, status.mask, top_pend);
    assign ack_en = (state_q == CTL_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CTL_IDLE;
            take_q  <= 1'b0;
            lvl_q   <= LVL_NONE;
        end else begin
            take_q <= accept;
            case (state_q)
                CTL_IDLE: if (accept) begin
                    state_q <= CTL_WAIT;
                    lvl_q   <= stable_lvl;
                end
                CTL_WAIT: if (ack_valid_i) state_q <= CTL_IDLE;
                default:  state_q <= CTL_IDLE;
            endcase
        end
    end

    irqc_status #(.RST_MASK(RST_MASK)) u_status (
        .clk          (clk),
        .rst          (rst),
        .accept_i     (accept),
        .accept_lvl_i (stable_lvl),
        .wr_en_i      (sr_wr_en_i),
        .wr_sup_i     (sr_wr_sup_i),
        .wr_mask_i    (sr_wr_mask_i),
        .status_o     (status)
    );

    irqc_vector u_vector (
        .clk         (clk),
        .rst         (rst),
        .ack_en_i    (ack_en),
        .ack_valid_i (ack_valid_i),
        .ack_kind_i  (ack_kind_i),
        .ack_vec_i   (ack_vec_i),
        .lvl_i       (lvl_q),
        .vec_o       (vec)
    );

    assign take_o      = take_q;
    assign ack_pend_o  = ack_en;
    assign ack_lvl_o   = lvl_q;
    assign vec_valid_o = vec.valid;
    assign vec_num_o   = vec.num;
    assign vec_addr_o  = vec.addr;
    assign mask_o      = status.mask;
    assign sup_o       = status.sup;
    assign ssp_sel_o   = status.sup;

    // R5: a take is a single-cycle pulse
    p_take_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        take_q |=> !take_q);

    // R5: the raised mask and the serviced level agree on a take
    p_take_mask_r5: assert property (@(posedge clk) disable iff (rst)
        take_q |-> (status.mask == lvl_q && status.sup && ack_en));

    // R3: a take of levels below the top follows a level above the old mask
    p_mask_rule_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && stable_lvl != LVL_TOP) |-> (stable_lvl > status.mask));

endmodule

// File: tb/irq_level_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_level_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] irq_lvl_i;
    logic       sr_wr_en_i;
    logic       sr_wr_sup_i;
    logic [2:0] sr_wr_mask_i;
    logic       ack_valid_i;
    logic [1:0] ack_kind_i;
    logic [7:0] ack_vec_i;
    logic       take_o;
    logic       ack_pend_o;
    logic [2:0] ack_lvl_o;
    logic       vec_valid_o;
    logic [7:0] vec_num_o;
    logic [9:0] vec_addr_o;
    logic [2:0] mask_o;
    logic       sup_o;
    logic       ssp_sel_o;

    int n_checks = 0;
    int n_fails  = 0;
    int m_mask;
    int m_sup;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_level_ctrl dut_i (
        .clk(clk), .rst(rst), .irq_lvl_i(irq_lvl_i),
        .sr_wr_en_i(sr_wr_en_i), .sr_wr_sup_i(sr_wr_sup_i), .sr_wr_mask_i(sr_wr_mask_i),
        .ack_valid_i(ack_valid_i), .ack_kind_i(ack_kind_i), .ack_vec_i(ack_vec_i),
        .take_o(take_o), .ack_pend_o(ack_pend_o), .ack_lvl_o(ack_lvl_o),
        .vec_valid_o(vec_valid_o), .vec_num_o(vec_num_o), .vec_addr_o(vec_addr_o),
        .mask_o(mask_o), .sup_o(sup_o), .ssp_sel_o(ssp_sel_o)
    );

    function automatic int exp_vec(int kind, int dev, int lvl);
        if (kind == 0) return dev;
        if (kind == 1) return 24 + lvl;
        return 24;
    endfunction

    function automatic bit exp_take(int lvl, int mask);
        if (lvl == 7) return 1'b1;
        return (lvl != 0) && (lvl > mask);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sr_write(int sup, int mask);
        sr_wr_en_i   = 1'b1;
        sr_wr_sup_i  = sup[0];
        sr_wr_mask_i = mask[2:0];
        cyc();
        sr_wr_en_i = 1'b0;
        if (m_sup != 0) begin
            m_sup  = sup;
            m_mask = mask;
        end
        check(mask_o == m_mask[2:0], "R7 mask after write", mask_o, m_mask);
        check(sup_o == m_sup[0], "R7 sup after write", sup_o, m_sup);
    endtask

    task automatic go_idle();
        irq_lvl_i = 3'd0;
        repeat (4) cyc();
    endtask

    // applies a level and reports the cycle of the first take (0 = none)
    task automatic try_level(int lvl, bit exp, string req);
        int first = 0;
        irq_lvl_i = lvl[2:0];
        for (int c = 1; c <= 5; c++) begin
            cyc();
            if (take_o && first == 0) first = c;
            if (c == 3 && take_o) begin
                check(mask_o == lvl[2:0], "R5 mask raised on take", mask_o, lvl);
                check(sup_o && ssp_sel_o, "R5 supervisor on take", sup_o, 1);
                check(ack_lvl_o == lvl[2:0], "R5 serviced level", ack_lvl_o, lvl);
            end
        end
        check(first == (exp ? 3 : 0), req, first, exp ? 3 : 0);
        if (exp) begin
            m_mask = lvl;
            m_sup  = 1;
            check(ack_pend_o == 1'b1, "R5 ack pending", ack_pend_o, 1);
        end
    endtask

    task automatic do_ack(int kind, int dev, int lvl);
        int ev;
        ev = exp_vec(kind, dev, lvl);
        ack_valid_i = 1'b1;
        ack_kind_i  = kind[1:0];
        ack_vec_i   = dev[7:0];
        cyc();
        ack_valid_i = 1'b0;
        check(vec_valid_o == 1'b1, "R6 vector valid", vec_valid_o, 1);
        check(vec_num_o == ev[7:0], "R6 vector number", vec_num_o, ev);
        check(vec_addr_o == 10'(ev * 4), "R6 vector address", vec_addr_o, ev * 4);
        check(ack_pend_o == 1'b0, "R6 wait ended", ack_pend_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; irq_lvl_i = 0; sr_wr_en_i = 0; sr_wr_sup_i = 0; sr_wr_mask_i = 0;
        ack_valid_i = 0; ack_kind_i = 0; ack_vec_i = 0;
        m_mask = 7; m_sup = 1;
        @(negedge clk);
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        check(sup_o && ssp_sel_o, "R1 supervisor after reset", sup_o, 1);
        check(mask_o == 3'd7, "R1 mask after reset", mask_o, 7);
        check(!take_o && !ack_pend_o && !vec_valid_o, "R1 quiet outputs", take_o, 0);

        // R3 masked and equal levels
        try_level(3, 0, "R3 level 3 under mask 7");
        go_idle();
        sr_write(1, 2);
        try_level(2, 0, "R3 level equal to mask");
        go_idle();
        try_level(0, 0, "R3 level 0 never taken");
        try_level(3, 1, "R2 R3 level 3 over mask 2 taken at third edge");
        // R5 no take while pending, R9 higher level after the ack
        irq_lvl_i = 3'd5;
        repeat (4) begin
            cyc();
            check(!take_o, "R5 no take while pending", take_o, 0);
        end
        do_ack(1, 0, 3);
        check(!take_o, "R9 no take in ack cycle", take_o, 0);
        cyc();
        check(take_o && ack_lvl_o == 3'd5, "R9 higher level taken after ack", ack_lvl_o, 5);
        m_mask = 5;
        do_ack(0, 8'h40, 5);
        try_level(4, 0, "R9 lower level stays untaken");
        go_idle();

        // R6 stray acknowledge ignored
        ack_valid_i = 1'b1;
        cyc();
        ack_valid_i = 1'b0;
        check(!vec_valid_o, "R6 stray ack ignored", vec_valid_o, 0);

        // R2 one-edge glitch
        sr_write(1, 0);
        irq_lvl_i = 3'd4;
        cyc();
        irq_lvl_i = 3'd0;
        for (int c = 0; c < 5; c++) begin
            cyc();
            check(!take_o, "R2 glitch not taken", take_o, 0);
        end

        // R7 user-state write refused, R5 forced supervisor
        sr_write(0, 0);
        check(!ssp_sel_o, "R7 user stack selected", ssp_sel_o, 0);
        sr_write(1, 7);
        try_level(1, 1, "R5 level 1 taken from user state");
        do_ack(2, 0, 1);
        go_idle();

        // R4 level 7 under mask 7, once per change
        sr_write(1, 7);
        try_level(7, 1, "R4 level 7 ignores mask");
        do_ack(1, 0, 7);
        for (int c = 0; c < 10; c++) begin
            cyc();
            check(!take_o, "R4 held level 7 not retaken", take_o, 0);
        end
        go_idle();
        try_level(7, 1, "R4 level 7 retaken after change");
        do_ack(3, 0, 7);
        go_idle();

        // R8 take and status write on the same edge
        sr_write(1, 1);
        irq_lvl_i = 3'd4;
        cyc();
        cyc();
        sr_wr_en_i = 1'b1; sr_wr_sup_i = 1'b0; sr_wr_mask_i = 3'd6;
        cyc();
        sr_wr_en_i = 1'b0;
        check(take_o, "R8 take on shared edge", take_o, 1);
        check(mask_o == 3'd4, "R8 write discarded mask", mask_o, 4);
        check(sup_o, "R8 write discarded sup", sup_o, 1);
        m_mask = 4; m_sup = 1;
        do_ack(0, 8'hC3, 4);
        go_idle();

        // random mix, R3 R4 R5 R6 R7
        for (int it = 0; it < 80; it++) begin
            int lvl;
            bit e;
            go_idle();
            if (($urandom % 2) == 0) sr_write(int'($urandom % 2), int'($urandom % 8));
            if (m_sup == 0 && ($urandom % 2) == 0) begin
                m_sup = 1; // restore supervisor via a taken level 7
                try_level(7, 1, "R4 random level 7");
                do_ack(1, 0, 7);
                go_idle();
            end
            lvl = int'($urandom % 8);
            e = exp_take(lvl, m_mask);
            try_level(lvl, e, "R3 random level decision");
            if (e) do_ack(int'($urandom % 4), int'($urandom % 256), lvl);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule